// File: doc/BRIEF.md
# Coprocessor Bus Handshake Controller

This block is the host-facing bus front end of a numeric coprocessor. It watches the host's address strobe, ready, read/write and select lines and answers the cycles addressed to the coprocessor. It also runs the handshake outputs that tell the host when the coprocessor is busy, when it wants operand data moved, and when an unmasked exception is pending. One clock, `clk2`, serves as both the doubled bus clock and the numeric clock. All cycle counts below are counted in `clk2` edges.

The reset input is measured as well as obeyed. A pulse that is too short is flagged. An instruction write that arrives too soon after reset is flagged and not acted on. The internal bus clock runs at half the `clk2` rate, and its phase is fixed by the release of reset.

The data bus is modelled as a separate input word, output word and output-enable. The output-enable is high only during the data phase of a read. The execution engine's busy flag, its exception summary and the operand buffer's ready flag enter as plain inputs.

Top module: `cop_bus_handshake`

## Requirements
- R1: From the second `clk2` edge with `rst_in` high until release: `ready_n`=1, `busy_n`=1, `xfer_req`=0, `error_n`=0 and `data_oe`=0. Reset abandons any bus cycle in progress.
- R2: `viol_rst_short` becomes 1 on the first edge after release if `rst_in` was high for fewer than 40 edges; a 40-edge pulse leaves it 0. It reads 0 while `rst_in` is high.
- R3: A selected write whose address is sampled at the N-th edge after release, with N ≤ 50, sets the sticky `viol_early_wr` and its word has no effect on the error output. The earliest unflagged sample is edge 52. The flag clears during reset.
- R4: The internal bus clock is `clk2`/2. Address strobes are sampled only on even edges after release, counting the first low-reset edge as 1. A strobe held low only across an odd edge gets no response.
- R5: A sampled cycle is answered (`ready_n` low for exactly two `clk2` cycles, starting after the sampling edge) only when `sel_en`=1, `sel_a_n`=0 and `sel_b`=1. Otherwise there is no answer, and `wr` is looked at only at the sampling edge.
- R6: After any sampled strobe, a new strobe is ignored until `rdy_n` has been seen low on an even edge.
- R7: `data_oe` is 1 and `data_out` carries `rd_word` (captured at the sampling edge) only while `ready_n` is low in a read cycle. A write never drives the bus, and `data_out` is 0 whenever `data_oe` is 0.
- R8: After reset `error_n` stays low, as a presence indication, until a clearing word is written.
- R9: Only a write word with bits [31:17]=0 and bit 16 (wait flag)=0 clears an active error. Bits [15:0] must be one of 16'hDBE3 (initialise), 16'hDBE2 (clear exceptions), 16'hD930 (store environment) or 16'hDD30 (save). `error_n` then goes high on the second edge after the cycle's final edge, and any other word leaves it low.
- R10: While the error is inactive, `eng_es`=1 makes `error_n` low one edge later. It then stays low after `eng_es` drops.
- R11: `xfer_req` is `fifo_rdy & eng_busy` registered once.
- R12: `busy_n` is the registered negation of `eng_busy | xfer_req`, so `xfer_req` always falls at least one edge before `busy_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Doubled bus clock, also the numeric clock |
| rst_in | input | 1 | System reset, active high, synchronous to clk2 |
| ads_n | input | 1 | Address strobe, active low |
| rdy_n | input | 1 | Host bus ready, active low |
| wr | input | 1 | 1 = write cycle, 0 = read cycle |
| sel_en | input | 1 | Status-enable select, active high |
| sel_a_n | input | 1 | First coprocessor select, active low |
| sel_b | input | 1 | Second coprocessor select, active high |
| data_in | input | 32 | Data bus value seen from the host |
| rd_word | input | 32 | Word returned on a read |
| eng_busy | input | 1 | Execution engine is running an instruction |
| fifo_rdy | input | 1 | Operand buffer ready to exchange data |
| eng_es | input | 1 | Exception summary status bit |
| ready_n | output | 1 | Coprocessor ready, active low |
| busy_n | output | 1 | Busy, active low |
| xfer_req | output | 1 | Operand transfer request |
| error_n | output | 1 | Error, active low |
| data_out | output | 32 | Data driven to the bus on reads |
| data_oe | output | 1 | Data bus output enable (0 = high impedance) |
| viol_rst_short | output | 1 | Reset pulse shorter than the minimum |
| viol_early_wr | output | 1 | Write arrived inside the post-reset quiet time |

## Verification
A phase register that is off by one edge shows at once: strobes on even edges go unanswered, and `ready_n` is late by one `clk2` cycle. A bus-free flag or cycle state left wrong shows on the next strobe, either as a missing answer or as a bus driven with no cycle. A miscounted reset or quiet counter shows only at the exact 39/40 and 50/52 limits, and only in the violation flags and in whether an early clearing word takes effect. An error or busy register stuck in the wrong state shows within one or two edges of the clearing write or the engine change.

// File: rtl/cbh_pkg.sv
package cbh_pkg;

    localparam int unsigned CBH_DW  = 32;
    localparam int unsigned CBH_OPW = 16;

    localparam logic [CBH_OPW-1:0] OPC_INIT  = 16'hDBE3;
    localparam logic [CBH_OPW-1:0] OPC_CLEX  = 16'hDBE2;
    localparam logic [CBH_OPW-1:0] OPC_STENV = 16'hD930;
    localparam logic [CBH_OPW-1:0] OPC_SAVE  = 16'hDD30;

    typedef enum logic {
        BS_IDLE = 1'b0,
        BS_DATA = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic wr;
        logic early;
    } bus_txn_t;

    function automatic logic sel_match(input logic en, input logic a_n, input logic b);
        return en & ~a_n & b;
    endfunction

    function automatic logic is_clear_word(input logic [CBH_DW-1:0] w);
        logic opc_hit;
        opc_hit = (w[CBH_OPW-1:0] == OPC_INIT)  || (w[CBH_OPW-1:0] == OPC_CLEX) ||
                  (w[CBH_OPW-1:0] == OPC_STENV) || (w[CBH_OPW-1:0] == OPC_SAVE);
        return opc_hit && (w[CBH_DW-1:CBH_OPW] == '0);
    endfunction

endpackage

// File: rtl/cbh_reset_seq.sv
module cbh_reset_seq #(
    parameter int unsigned MIN_RST = 40,
    parameter int unsigned QUIET   = 50
) (
    input  logic clk2,
    input  logic rst_in,
    output logic phase,
    output logic quiet_open,
    output logic viol_short
);
    localparam int unsigned RC_W = $clog2(MIN_RST + 1);
    localparam int unsigned QC_W = $clog2(QUIET + 1);
    localparam logic [RC_W-1:0] RC_MAX = RC_W'(MIN_RST);
    localparam logic [QC_W-1:0] QC_MAX = QC_W'(QUIET);

    logic [RC_W-1:0] rc_q;
    logic [QC_W-1:0] qc_q;
    logic            rst_q;

    always_ff @(posedge clk2) begin
        rst_q <= rst_in;
    end

    // Width of the reset pulse, saturating at the minimum.
    always_ff @(posedge clk2) begin
        if (rst_in) begin
            if (rc_q != RC_MAX) rc_q <= rc_q + 1'b1;
        end else begin
            rc_q <= '0;
        end
    end

    always_ff @(posedge clk2) begin
        if (rst_in) begin
            viol_short <= 1'b0;
        end else if (rst_q && (rc_q < RC_MAX)) begin
            viol_short <= 1'b1;
        end
    end

    // Edges since release, saturating at the quiet limit.
    always_ff @(posedge clk2) begin
        if (rst_in) begin
            qc_q <= '0;
        end else if (qc_q != QC_MAX) begin
            qc_q <= qc_q + 1'b1;
        end
    end

    // Internal bus clock: phase is 0 on the first low edge.
    always_ff @(posedge clk2) begin
        if (rst_in) phase <= 1'b0;
        else        phase <= ~phase;
    end

    assign quiet_open = (qc_q == QC_MAX);

    p_phase_toggles_r4: assert property (@(posedge clk2) disable iff (rst_in)
        $past(!rst_in) |-> (phase != $past(phase)));

    p_short_only_at_release_r2: assert property (@(posedge clk2) disable iff (rst_in)
        $rose(viol_short) |-> $past(rst_in, 2));

endmodule

// File: rtl/cbh_bus_unit.sv
module cbh_bus_unit
    import cbh_pkg::*;
(
    input  logic              clk2,
    input  logic              rst_in,
    input  logic              phase,
    input  logic              quiet_open,
    input  logic              ads_n,
    input  logic              rdy_n,
    input  logic              wr,
    input  logic              sel_en,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic [CBH_DW-1:0] data_in,
    input  logic [CBH_DW-1:0] rd_word,
    output logic              ready_n,
    output logic              data_oe,
    output logic [CBH_DW-1:0] data_out,
    output logic              clr_err,
    output logic              viol_early
);
    bus_state_e        state_q;
    bus_txn_t          txn_q;
    logic              bus_free_q;
    logic [CBH_DW-1:0] dout_q;
    logic              sample;
    logic              hit;

    assign sample = phase && !ads_n && bus_free_q && (state_q == BS_IDLE);
    assign hit    = sample && sel_match(sel_en, sel_a_n, sel_b);

    always_ff @(posedge clk2) begin
        if (rst_in) begin
            state_q    <= BS_IDLE;
            txn_q      <= '0;
            bus_free_q <= 1'b1;
            dout_q     <= '0;
            clr_err    <= 1'b0;
            viol_early <= 1'b0;
        end else begin
            clr_err <= 1'b0;
            if (phase) begin
                if (sample)      bus_free_q <= 1'b0;
                else if (!rdy_n) bus_free_q <= 1'b1;
                case (state_q)
                    BS_IDLE: begin
                        if (hit) begin
                            state_q     <= BS_DATA;
                            txn_q.wr    <= wr;
                            txn_q.early <= wr && !quiet_open;
                            if (wr && !quiet_open) viol_early <= 1'b1;
                            if (!wr) dout_q <= rd_word;
                        end
                    end
                    default: begin
                        state_q <= BS_IDLE;
                        if (txn_q.wr && !txn_q.early && is_clear_word(data_in))
                            clr_err <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign ready_n  = (state_q != BS_DATA);
    assign data_oe  = (state_q == BS_DATA) && !txn_q.wr;
    assign data_out = data_oe ? dout_q : '0;

    p_ready_needs_select_r5: assert property (@(posedge clk2) disable iff (rst_in)
        $fell(ready_n) |-> $past(sel_en && !sel_a_n && sel_b && !ads_n && phase));

    p_ready_two_cycles_r5: assert property (@(posedge clk2) disable iff (rst_in)
        $fell(ready_n) |=> !ready_n);

    p_oe_read_only_r7: assert property (@(posedge clk2) disable iff (rst_in)
        $rose(data_oe) |-> $past(!wr));

    p_early_flagged_r3: assert property (@(posedge clk2) disable iff (rst_in)
        (hit && wr && !quiet_open) |=> viol_early);

    p_free_needed_r6: assert property (@(posedge clk2) disable iff (rst_in)
        (sample && rdy_n) |=> !bus_free_q);

endmodule

// File: rtl/cbh_status.sv
module cbh_status (
    input  logic clk2,
    input  logic rst_in,
    input  logic eng_busy,
    input  logic fifo_rdy,
    input  logic eng_es,
    input  logic clr_err,
    output logic xfer_req,
    output logic busy_n,
    output logic error_n
);
    logic xfer_q;
    logic busy_q;
    logic err_q;

    always_ff @(posedge clk2) begin
        if (rst_in) begin
            xfer_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            xfer_q <= fifo_rdy & eng_busy;
            busy_q <= eng_busy | xfer_q;
        end
    end

    // Presence indication out of reset, then sticky until a clearing word.
    always_ff @(posedge clk2) begin
        if (rst_in)      err_q <= 1'b1;
        else if (err_q)  err_q <= !clr_err;
        else             err_q <= eng_es;
    end

    assign xfer_req = xfer_q;
    assign busy_n   = !busy_q;
    assign error_n  = !err_q;

    p_xfer_drops_first_r12: assert property (@(posedge clk2) disable iff (rst_in)
        $fell(busy_q) |-> !$past(xfer_q));

    p_err_sticky_r9: assert property (@(posedge clk2) disable iff (rst_in)
        (err_q && !clr_err) |=> err_q);

    p_err_follows_es_r10: assert property (@(posedge clk2) disable iff (rst_in)
        (!err_q && eng_es) |=> err_q);

endmodule

// File: rtl/cop_bus_handshake.sv
module cop_bus_handshake
    import cbh_pkg::*;
#(
    parameter int unsigned MIN_RST = 40,
    parameter int unsigned QUIET   = 50
) (
    input  logic              clk2,
    input  logic              rst_in,
    input  logic              ads_n,
    input  logic              rdy_n,
    input  logic              wr,
    input  logic              sel_en,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic [CBH_DW-1:0] data_in,
    input  logic [CBH_DW-1:0] rd_word,
    input  logic              eng_busy,
    input  logic              fifo_rdy,
    input  logic              eng_es,
    output logic              ready_n,
    output logic              busy_n,
    output logic              xfer_req,
    output logic              error_n,
    output logic [CBH_DW-1:0] data_out,
    output logic              data_oe,
    output logic              viol_rst_short,
    output logic              viol_early_wr
);
    logic phase;
    logic quiet_open;
    logic clr_err;

    cbh_reset_seq #(.MIN_RST(MIN_RST), .QUIET(QUIET)) u_rst (
        .clk2       (clk2),
        .rst_in     (rst_in),
        .phase      (phase),
        .quiet_open (quiet_open),
        .viol_short (viol_rst_short)
    );

    cbh_bus_unit u_bus (
        .clk2       (clk2),
        .rst_in     (rst_in),
        .phase      (phase),
        .quiet_open (quiet_open),
        .ads_n      (ads_n),
        .rdy_n      (rdy_n),
        .wr         (wr),
        .sel_en     (sel_en),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .data_in    (data_in),
        .rd_word    (rd_word),
        .ready_n    (ready_n),
        .data_oe    (data_oe),
        .data_out   (data_out),
        .clr_err    (clr_err),
        .viol_early (viol_early_wr)
    );

    cbh_status u_stat (
        .clk2     (clk2),
        .rst_in   (rst_in),
        .eng_busy (eng_busy),
        .fifo_rdy (fifo_rdy),
        .eng_es   (eng_es),
        .clr_err  (clr_err),
        .xfer_req (xfer_req),
        .busy_n   (busy_n),
        .error_n  (error_n)
    );

    p_reset_pins_r1: assert property (@(posedge clk2)
        (rst_in && $past(rst_in)) |-> (ready_n && busy_n && !xfer_req && !error_n && !data_oe));

endmodule

// File: tb/cop_bus_handshake_bench.sv
`timescale 1ns/1ps
module cop_bus_handshake_bench;

    logic        clk2 = 1'b0;
    logic        rst_in = 1'b0;
    logic        ads_n = 1'b1, rdy_n = 1'b1, wr = 1'b0;
    logic        sel_en = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0;
    logic [31:0] data_in = '0, rd_word = '0;
    logic        eng_busy = 1'b0, fifo_rdy = 1'b0, eng_es = 1'b0;
    logic        ready_n, busy_n, xfer_req, error_n, data_oe;
    logic [31:0] data_out;
    logic        viol_rst_short, viol_early_wr;

    int n_chk = 0;
    int n_err = 0;
    int edge_cnt = 0;
    bit done = 0;

    always #2.5 clk2 = ~clk2;

    always @(posedge clk2) begin
        if (rst_in) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
    end

    cop_bus_handshake u_cop_bus_handshake (
        .clk2(clk2), .rst_in(rst_in), .ads_n(ads_n), .rdy_n(rdy_n), .wr(wr),
        .sel_en(sel_en), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .data_in(data_in), .rd_word(rd_word),
        .eng_busy(eng_busy), .fifo_rdy(fifo_rdy), .eng_es(eng_es),
        .ready_n(ready_n), .busy_n(busy_n), .xfer_req(xfer_req), .error_n(error_n),
        .data_out(data_out), .data_oe(data_oe),
        .viol_rst_short(viol_rst_short), .viol_early_wr(viol_early_wr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_clear(input logic [31:0] w);
        return (w[31:16] == 16'h0) &&
               (w[15:0] == 16'hDBE3 || w[15:0] == 16'hDBE2 ||
                w[15:0] == 16'hD930 || w[15:0] == 16'hDD30);
    endfunction

    task automatic step();
        @(posedge clk2); @(negedge clk2);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk2);
        ads_n = 1'b1; rdy_n = 1'b1; rst_in = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(posedge clk2);
            if (i == 2) begin
                @(negedge clk2);
                check("R1 ready_n in reset", ready_n, 1);
                check("R1 busy_n in reset", busy_n, 1);
                check("R1 xfer_req in reset", xfer_req, 0);
                check("R1 error_n in reset", error_n, 0);
                check("R1 data_oe in reset", data_oe, 0);
                check("R2 short flag clear in reset", viol_rst_short, 0);
                check("R3 early flag clear in reset", viol_early_wr, 0);
            end
        end
        @(negedge clk2);
        rst_in = 1'b0;
    endtask

    task automatic wait_edge(input int k);
        while (edge_cnt < k) @(negedge clk2);
    endtask

    // One bus cycle starting at the next even edge; blocked marks an expected ignore (R6).
    task automatic bus_cyc(input bit w, input bit en, input bit an, input bit b,
                           input logic [31:0] word, input logic [31:0] rdw,
                           input bit give_rdy, input bit blocked);
        bit resp;
        resp = en && !an && b && !blocked;
        while (edge_cnt % 2 == 0) @(negedge clk2);
        ads_n = 1'b0; wr = w; sel_en = en; sel_a_n = an; sel_b = b;
        data_in = word; rd_word = rdw;
        step();
        ads_n = 1'b1; wr = 1'($urandom);
        check("R5 ready_n data phase 1", ready_n, !resp);
        check("R7 data_oe data phase 1", data_oe, resp && !w);
        check("R7 data_out data phase 1", data_out, (resp && !w) ? rdw : 32'h0);
        step();
        if (give_rdy) rdy_n = 1'b0;
        check("R5 ready_n data phase 2", ready_n, !resp);
        check("R7 data_oe data phase 2", data_oe, resp && !w);
        step();
        rdy_n = 1'b1;
        check("R5 ready_n after cycle", ready_n, 1);
        check("R7 data_oe after cycle", data_oe, 0);
    endtask

    task automatic write_word(input logic [31:0] w);
        bus_cyc(1'b1, 1'b1, 1'b0, 1'b1, w, 32'h0, 1'b1, 1'b0);
        step();
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(); step();
        do_reset(45);
        check("R2 45-edge reset not short", viol_rst_short, 0);
        check("R8 presence after reset", error_n, 0);
        wait_edge(52);
        check("R8 presence held", error_n, 0);

        // R4: strobe held only across an odd edge is not sampled
        while (edge_cnt % 2 == 1) @(negedge clk2);
        ads_n = 1'b0; sel_en = 1'b1; sel_a_n = 1'b0; sel_b = 1'b1; wr = 1'b0;
        step();
        ads_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            check("R4 no answer to odd-edge strobe", ready_n, 1);
            step();
        end

        // R5/R7: random selects, directions and words
        for (int i = 0; i < 60; i++) begin
            bit sel_all, w;
            logic [2:0] s;
            sel_all = ($urandom % 4) != 0;
            s = sel_all ? 3'b101 : 3'($urandom);
            w = 1'($urandom);
            bus_cyc(w, s[2], s[1], s[0], $urandom | 32'h8000_0000, $urandom, 1'b1, 1'b0);
        end
        check("R8 error still low after unrelated cycles", error_n, 0);

        // R6: unselected cycle with no ready, then a selected strobe is ignored
        bus_cyc(1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 1'b0, 1'b0);
        bus_cyc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0, 32'hCAFE_0001, 1'b1, 1'b1);
        bus_cyc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0, 32'hCAFE_0002, 1'b1, 1'b0);

        // R9: non-clearing words leave error active
        write_word({15'h0, 1'b1, 16'hDBE3});
        check("R9 wait-flagged init does not clear", error_n, 0);
        write_word({15'h1, 1'b0, 16'hDBE2});
        check("R9 nonzero upper bits do not clear", error_n, 0);
        write_word(32'h0000_D9F0);
        check("R9 other opcode does not clear", error_n, 0);
        bus_cyc(1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_DBE3, 32'h1, 1'b1, 1'b0);
        step();
        check("R9 read does not clear", error_n, 0);
        write_word(32'h0000_DD30);
        check("R9 save clears", error_n, !exp_clear(32'h0000_DD30) ? 0 : 1);

        // R10 then clears with the other opcodes
        begin
            logic [31:0] clr_set [3];
            clr_set[0] = 32'h0000_D930; clr_set[1] = 32'h0000_DBE2; clr_set[2] = 32'h0000_DBE3;
            for (int i = 0; i < 3; i++) begin
                eng_es = 1'b1; step(); eng_es = 1'b0;
                check("R10 error follows es", error_n, 0);
                repeat (5) step();
                check("R10 error held after es drops", error_n, 0);
                write_word(clr_set[i]);
                check("R9 clearing opcode", error_n, 1);
            end
        end

        // R11/R12: random engine activity
        for (int i = 0; i < 300; i++) begin
            bit b, f, exp_x, exp_b, prev_x;
            prev_x = xfer_req;
            b = ($urandom % 3) != 0;
            f = 1'($urandom);
            eng_busy = b; fifo_rdy = f;
            exp_x = b & f;
            exp_b = b | prev_x;
            step();
            check("R11 xfer_req", xfer_req, exp_x);
            check("R12 busy_n", busy_n, !exp_b);
        end
        eng_busy = 1'b0; fifo_rdy = 1'b0;
        eng_busy = 1'b1; fifo_rdy = 1'b1; step(); step();
        eng_busy = 1'b0; fifo_rdy = 1'b0; step();
        check("R12 xfer dropped first", xfer_req, 0);
        check("R12 busy still active", busy_n, 0);
        step();
        check("R12 busy released after xfer", busy_n, 1);

        // R3: write at edge 50 is flagged and ignored; edge 52 is accepted
        do_reset(40);
        check("R2 40-edge reset not short", viol_rst_short, 0);
        wait_edge(49);
        write_word(32'h0000_DBE3);
        check("R3 early write flagged at edge 50", viol_early_wr, 1);
        check("R3 early clearing word ignored", error_n, 0);
        do_reset(40);
        check("R3 flag cleared by reset", viol_early_wr, 0);
        wait_edge(51);
        write_word(32'h0000_DBE2);
        check("R3 write at edge 52 not flagged", viol_early_wr, 0);
        check("R3 write at edge 52 acted on", error_n, 1);

        // R2 limits
        do_reset(39);
        step();
        check("R2 39-edge reset flagged", viol_rst_short, 1);
        do_reset(40);
        step();
        check("R2 40-edge reset accepted", viol_rst_short, 0);

        // R1: reset aborts a read in progress
        wait_edge(52);
        while (edge_cnt % 2 == 0) @(negedge clk2);
        ads_n = 1'b0; wr = 1'b0; sel_en = 1'b1; sel_a_n = 1'b0; sel_b = 1'b1; rd_word = 32'h1234_5678;
        step();
        ads_n = 1'b1;
        check("R7 read drives bus before abort", data_oe, 1);
        do_reset(45);
        check("R1 bus released after abort", data_oe, 0);
        check("R1 ready_n after abort", ready_n, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk2);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule